// File: doc/BRIEF.md
# Serial NOR Flash Identification Probe

This block performs the discovery sequence that a system runs once after power-up to find out which serial NOR flash sits on a four-wire SPI link and how that flash should be erased. A one-cycle `start` pulse launches the run. The block first clocks the bus with chip select inactive, so that the flash can finish any command left half-done. It then issues the legacy manufacturer/device command and keeps the device byte. Next it issues the standard JEDEC identification command and keeps the vendor, memory-type and capacity bytes. It leaves the bus deselected when it ends.

From the captured identifier the block works out the erase geometry: a sector-size word, the opcode that erases one sector, and the number of sectors. When the parameter `FOUR_K_EN` is set, two known vendor/type pairs get a 4 KB sector layout; every other part gets a 64 KB layout. A capacity code outside the supported range marks the flash unusable, reports error code 7 and releases the SPI outputs. SCK runs at a parameterised division of the system clock. A host or boot controller reads the results once `done` pulses.

Top module: `flash_id_probe`

## Requirements
- R1: After reset, busy, done, enabled, spi_oe and spi_sck are 0, spi_cs_n is 1 and err_code is 0.
- R2: A start pulse seen while idle raises busy on the next clock edge. Busy stays high until done pulses. Done is high for exactly one cycle, and in that cycle busy is already low.
- R3: A run opens with exactly 264 SCK rising edges while spi_cs_n is high: 256 idle clocks followed by 8 select clocks. Only after these does chip select go low.
- R4: Every SCK high phase lasts exactly HALF_DIV system clocks. Every SCK low phase within a run lasts at least HALF_DIV system clocks.
- R5: The first selected transfer has 40 SCK rising edges. It sends opcode 0x90 MSB first, then 24 address bits that are all zero. The last 8 bits are read MSB first and appear on `device`.
- R6: Between the two transfers, spi_cs_n stays high for exactly 16 SCK rising edges. The second transfer has 32 rising edges. It sends opcode 0x9F, then reads three bytes MSB first: vendor, then memory type, then capacity code. Vendor and memory type appear on `vendor` and `mem_type`.
- R7: spi_mosi changes only while SCK is low, so it is stable at each rising edge. spi_miso is sampled at the rising edge.
- R8: A capacity code below 16 or above 24 gives enabled=0, err_code=7, spi_oe=0 and zero geometry outputs.
- R9: A supported capacity on a pair not listed in R10 gives enabled=1, err_code=0, spi_oe=1, sector_size=0x8010, erase_op=0xD8 and sector_count = 1 << (capacity − 16).
- R10: With FOUR_K_EN=1, vendor/type 0x01/0x40 or 0x20/0xBA with a supported capacity gives sector_size=0x800C, erase_op=0x20 and sector_count = 1 << (capacity − 12).
- R11: A start pulse while busy is ignored: no extra transfer happens and busy falls once the current run ends.
- R12: When a run ends, spi_cs_n is high, spi_sck is low, and exactly 8 deselect clocks have followed the last transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to run the probe |
| busy | output | 1 | High from the cycle after start until done |
| done | output | 1 | One-cycle pulse when the results are valid |
| enabled | output | 1 | Flash recognised and usable |
| err_code | output | 8 | 0 when the flash is usable, 7 when the capacity is unsupported |
| vendor | output | 8 | First identifier byte |
| mem_type | output | 8 | Second identifier byte |
| device | output | 8 | Byte returned by the legacy ID command |
| sector_size | output | 16 | Bit 15 set, low bits give log2 of the sector size |
| erase_op | output | 8 | Opcode that erases one sector |
| sector_count | output | 32 | Number of sectors |
| spi_oe | output | 1 | Drive enable for chip select, SCK and MOSI (0 = high impedance) |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Data to the flash |
| spi_miso | input | 1 | Data from the flash |

## Verification
Busy is due on the first clock edge after start is sampled. All results, `done` and the fall of `busy` appear together when the last deselect clock ends. The bench drives on falling clock edges and reads every output on falling clock edges. It waits for the `done` sample before it compares results, and it expects `done` to be low on the sample after that. The flash model also runs on falling clock edges. It sees each SCK or chip-select change one half period after the design registers it, so it can count SCK phase lengths in system clocks. It answers on spi_miso at the falling SCK edge, well before the rising edge at which the design samples.

// File: rtl/flash_probe_pkg.sv
package flash_probe_pkg;

    localparam int STEP_NUM  = 10;
    localparam int STEP_W    = 4;
    localparam int CLK_CNT_W = 9;
    localparam int RX_W      = 24;
    localparam int COUNT_W   = 32;

    localparam logic [STEP_W-1:0] STEP_DEVICE = STEP_W'(4);
    localparam logic [STEP_W-1:0] STEP_IDENT  = STEP_W'(8);
    localparam logic [STEP_W-1:0] STEP_LAST   = STEP_W'(STEP_NUM - 1);

    localparam logic [7:0] OP_LEGACY_ID = 8'h90;
    localparam logic [7:0] OP_JEDEC_ID  = 8'h9F;

    localparam logic [7:0] ERR_NONE        = 8'd0;
    localparam logic [7:0] ERR_UNSUPPORTED = 8'd7;

    localparam logic [7:0] CAP_MIN = 8'd16;
    localparam logic [7:0] CAP_MAX = 8'd24;

    localparam logic [15:0] SIZE_WORD_LARGE = 16'h8010;
    localparam logic [15:0] SIZE_WORD_SMALL = 16'h800C;
    localparam logic [7:0]  ERASE_LARGE     = 8'hD8;
    localparam logic [7:0]  ERASE_SMALL     = 8'h20;
    localparam logic [7:0]  LOG_LARGE       = 8'd16;
    localparam logic [7:0]  LOG_SMALL       = 8'd12;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_LAUNCH,
        PH_SHIFT,
        PH_JUDGE
    } probe_phase_e;

    // One entry of the bus script: chip-select level, number of SCK
    // periods, byte to send first, and whether MISO is collected.
    typedef struct packed {
        logic                 cs_n;
        logic [CLK_CNT_W-1:0] nclk;
        logic [7:0]           tx;
        logic                 capture;
    } probe_step_t;

    function automatic probe_step_t probe_step(input logic [STEP_W-1:0] idx);
        probe_step_t s;
        s.cs_n    = 1'b1;
        s.nclk    = CLK_CNT_W'(8);
        s.tx      = 8'h00;
        s.capture = 1'b0;
        case (idx)
            STEP_W'(0): s.nclk = CLK_CNT_W'(256);          // bus flush
            STEP_W'(2): begin s.cs_n = 1'b0; s.tx = OP_LEGACY_ID; end
            STEP_W'(3): begin s.cs_n = 1'b0; s.nclk = CLK_CNT_W'(24); end
            STEP_W'(4): begin s.cs_n = 1'b0; s.capture = 1'b1; end
            STEP_W'(7): begin s.cs_n = 1'b0; s.tx = OP_JEDEC_ID; end
            STEP_W'(8): begin s.cs_n = 1'b0; s.nclk = CLK_CNT_W'(24); s.capture = 1'b1; end
            default: ;                                     // 8 clocks, deselected
        endcase
        return s;
    endfunction

endpackage

// File: rtl/probe_spi_shifter.sv
module probe_spi_shifter
    import flash_probe_pkg::*;
#(
    parameter int HALF_DIV = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 launch,
    input  logic [CLK_CNT_W-1:0] nclk,
    input  logic [7:0]           tx_byte,
    input  logic                 capture,
    input  logic                 spi_miso,
    output logic                 spi_sck,
    output logic                 spi_mosi,
    output logic [RX_W-1:0]      rx_bits,
    output logic                 finished
);

    localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);

    typedef struct packed {
        logic                 active;
        logic                 sck;
        logic [DIV_W-1:0]     div;
        logic [CLK_CNT_W-1:0] left;
        logic [7:0]           tx;
        logic                 capture;
        logic [RX_W-1:0]      rx;
        logic                 fin;
    } shf_t;

    shf_t shf_d, shf_q;

    always_comb begin
        shf_d     = shf_q;
        shf_d.fin = 1'b0;
        if (launch) begin
            shf_d.active  = 1'b1;
            shf_d.sck     = 1'b0;
            shf_d.div     = '0;
            shf_d.left    = nclk;
            shf_d.tx      = tx_byte;
            shf_d.capture = capture;
        end else if (shf_q.active) begin
            if (shf_q.div == DIV_LAST) begin
                shf_d.div = '0;
                if (!shf_q.sck) begin
                    // rising edge: the flash drove MISO during the low phase
                    shf_d.sck = 1'b1;
                    if (shf_q.capture) begin
                        shf_d.rx = {shf_q.rx[RX_W-2:0], spi_miso};
                    end
                end else begin
                    // falling edge: next MOSI bit, one period consumed
                    shf_d.sck  = 1'b0;
                    shf_d.tx   = {shf_q.tx[6:0], 1'b0};
                    shf_d.left = shf_q.left - 1'b1;
                    if (shf_q.left == CLK_CNT_W'(1)) begin
                        shf_d.active = 1'b0;
                        shf_d.fin    = 1'b1;
                    end
                end
            end else begin
                shf_d.div = shf_q.div + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shf_q <= '0;
        end else begin
            shf_q <= shf_d;
        end
    end

    assign spi_sck  = shf_q.sck;
    assign spi_mosi = shf_q.tx[7];
    assign rx_bits  = shf_q.rx;
    assign finished = shf_q.fin;

endmodule

// File: rtl/probe_geometry.sv
module probe_geometry
    import flash_probe_pkg::*;
#(
    parameter bit FOUR_K_EN = 1'b1
) (
    input  logic [7:0]         vendor_id,
    input  logic [7:0]         type_id,
    input  logic [7:0]         cap_code,
    output logic               supported,
    output logic [15:0]        size_word,
    output logic [7:0]         erase_opcode,
    output logic [COUNT_W-1:0] count
);

    logic small_sec;
    logic [7:0] shift;

    generate
        if (FOUR_K_EN) begin : g_small_sectors
            assign small_sec = (vendor_id == 8'h01 && type_id == 8'h40) ||
                               (vendor_id == 8'h20 && type_id == 8'hBA);
        end else begin : g_large_only
            assign small_sec = 1'b0;
        end
    endgenerate

    always_comb begin
        supported    = (cap_code >= CAP_MIN) && (cap_code <= CAP_MAX);
        shift        = cap_code - (small_sec ? LOG_SMALL : LOG_LARGE);
        size_word    = small_sec ? SIZE_WORD_SMALL : SIZE_WORD_LARGE;
        erase_opcode = small_sec ? ERASE_SMALL : ERASE_LARGE;
        count        = supported ? (COUNT_W'(1) << shift) : '0;
    end

endmodule

// File: rtl/flash_id_probe.sv
module flash_id_probe
    import flash_probe_pkg::*;
#(
    parameter int HALF_DIV  = 4,
    parameter bit FOUR_K_EN = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    output logic               busy,
    output logic               done,
    output logic               enabled,
    output logic [7:0]         err_code,
    output logic [7:0]         vendor,
    output logic [7:0]         mem_type,
    output logic [7:0]         device,
    output logic [15:0]        sector_size,
    output logic [7:0]         erase_op,
    output logic [COUNT_W-1:0] sector_count,
    output logic               spi_oe,
    output logic               spi_cs_n,
    output logic               spi_sck,
    output logic               spi_mosi,
    input  logic               spi_miso
);

    typedef struct packed {
        probe_phase_e       phase;
        logic [STEP_W-1:0]  step;
        logic               busy;
        logic               done;
        logic               enabled;
        logic [7:0]         err;
        logic [7:0]         vendor;
        logic [7:0]         mtype;
        logic [7:0]         device;
        logic [7:0]         cap;
        logic [15:0]        size;
        logic [7:0]         erase;
        logic [COUNT_W-1:0] count;
        logic               oe;
        logic               cs_n;
    } seq_t;

    localparam seq_t SEQ_RESET = '{
        phase:   PH_IDLE,
        step:    '0,
        busy:    1'b0,
        done:    1'b0,
        enabled: 1'b0,
        err:     ERR_NONE,
        vendor:  8'h00,
        mtype:   8'h00,
        device:  8'h00,
        cap:     8'h00,
        size:    16'h0000,
        erase:   8'h00,
        count:   '0,
        oe:      1'b0,
        cs_n:    1'b1
    };

    seq_t seq_d, seq_q;

    probe_step_t        cur;
    logic               launch;
    logic [RX_W-1:0]    rx_bits;
    logic               step_fin;
    logic               geo_ok;
    logic [15:0]        geo_size;
    logic [7:0]         geo_erase;
    logic [COUNT_W-1:0] geo_count;

    assign cur    = probe_step(seq_q.step);
    assign launch = (seq_q.phase == PH_LAUNCH);

    probe_spi_shifter #(
        .HALF_DIV (HALF_DIV)
    ) u_shifter (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch   (launch),
        .nclk     (cur.nclk),
        .tx_byte  (cur.tx),
        .capture  (cur.capture),
        .spi_miso (spi_miso),
        .spi_sck  (spi_sck),
        .spi_mosi (spi_mosi),
        .rx_bits  (rx_bits),
        .finished (step_fin)
    );

    probe_geometry #(
        .FOUR_K_EN (FOUR_K_EN)
    ) u_geometry (
        .vendor_id    (seq_q.vendor),
        .type_id      (seq_q.mtype),
        .cap_code     (seq_q.cap),
        .supported    (geo_ok),
        .size_word    (geo_size),
        .erase_opcode (geo_erase),
        .count        (geo_count)
    );

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        case (seq_q.phase)
            PH_IDLE: begin
                if (start) begin
                    seq_d         = SEQ_RESET;
                    seq_d.phase   = PH_LAUNCH;
                    seq_d.busy    = 1'b1;
                    seq_d.oe      = 1'b1;
                end
            end
            PH_LAUNCH: begin
                seq_d.cs_n  = cur.cs_n;
                seq_d.phase = PH_SHIFT;
            end
            PH_SHIFT: begin
                if (step_fin) begin
                    if (seq_q.step == STEP_DEVICE) begin
                        seq_d.device = rx_bits[7:0];
                    end
                    if (seq_q.step == STEP_IDENT) begin
                        seq_d.vendor = rx_bits[23:16];
                        seq_d.mtype  = rx_bits[15:8];
                        seq_d.cap    = rx_bits[7:0];
                    end
                    if (seq_q.step == STEP_LAST) begin
                        seq_d.phase = PH_JUDGE;
                    end else begin
                        seq_d.step  = seq_q.step + 1'b1;
                        seq_d.phase = PH_LAUNCH;
                    end
                end
            end
            PH_JUDGE: begin
                seq_d.phase = PH_IDLE;
                seq_d.busy  = 1'b0;
                seq_d.done  = 1'b1;
                if (geo_ok) begin
                    seq_d.enabled = 1'b1;
                    seq_d.size    = geo_size;
                    seq_d.erase   = geo_erase;
                    seq_d.count   = geo_count;
                end else begin
                    seq_d.err = ERR_UNSUPPORTED;
                    seq_d.oe  = 1'b0;
                end
            end
            default: seq_d = SEQ_RESET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= SEQ_RESET;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy         = seq_q.busy;
    assign done         = seq_q.done;
    assign enabled      = seq_q.enabled;
    assign err_code     = seq_q.err;
    assign vendor       = seq_q.vendor;
    assign mem_type     = seq_q.mtype;
    assign device       = seq_q.device;
    assign sector_size  = seq_q.size;
    assign erase_op     = seq_q.erase;
    assign sector_count = seq_q.count;
    assign spi_oe       = seq_q.oe;
    assign spi_cs_n     = seq_q.cs_n;

endmodule

// File: rtl/flash_id_probe_chk.sv
module flash_id_probe_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       busy,
    input logic       done,
    input logic       enabled,
    input logic [7:0] err_code,
    input logic [7:0] erase_op,
    input logic       spi_oe,
    input logic       spi_cs_n,
    input logic       spi_sck,
    input logic       spi_mosi
);

    // R2
    done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R2
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    busy_ends_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R11
    busy_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R7
    mosi_steady_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sck |-> $stable(spi_mosi));

    // R12
    idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (spi_cs_n && !spi_sck));

    // R8
    reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !enabled) |-> (err_code == 8'd7 && !spi_oe));

    // R9
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && enabled) |-> (err_code == 8'd0 && spi_oe &&
                               (erase_op == 8'hD8 || erase_op == 8'h20)));

endmodule

bind flash_id_probe flash_id_probe_chk i_probe_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .enabled  (enabled),
    .err_code (err_code),
    .erase_op (erase_op),
    .spi_oe   (spi_oe),
    .spi_cs_n (spi_cs_n),
    .spi_sck  (spi_sck),
    .spi_mosi (spi_mosi)
);

// File: tb/test_flash_id_probe.sv
module test_flash_id_probe;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        busy, done, enabled;
    logic [7:0]  err_code, vendor, mem_type, device, erase_op;
    logic [15:0] sector_size;
    logic [31:0] sector_count;
    logic        spi_oe, spi_cs_n, spi_sck, spi_mosi;
    logic        spi_miso = 1'b0;

    int checks = 0;
    int errors = 0;

    flash_id_probe #(
        .HALF_DIV  (HALF),
        .FOUR_K_EN (1'b1)
    ) i_flash_id_probe (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .busy         (busy),
        .done         (done),
        .enabled      (enabled),
        .err_code     (err_code),
        .vendor       (vendor),
        .mem_type     (mem_type),
        .device       (device),
        .sector_size  (sector_size),
        .erase_op     (erase_op),
        .sector_count (sector_count),
        .spi_oe       (spi_oe),
        .spi_cs_n     (spi_cs_n),
        .spi_sck      (spi_sck),
        .spi_mosi     (spi_mosi),
        .spi_miso     (spi_miso)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // ---------------- flash model (runs on falling clock edges) ----------
    logic [7:0]  m_dev = 8'h00, m_ven = 8'h00, m_typ = 8'h00, m_cap = 8'h00;
    logic        model_clear = 1'b0;
    int          m_bits, m_txn, m_high_rises, hi_cnt, lo_cnt, phase_bad, mosi_bad;
    int          m_gap [0:3];
    int          m_txn_bits [0:3];
    logic [7:0]  m_cmd;
    logic [23:0] m_addr;
    logic [7:0]  m_txn_cmd [0:3];
    logic [23:0] m_txn_addr [0:3];
    logic        psck = 1'b0, pcs = 1'b1, pmosi = 1'b0;

    function automatic logic resp_bit(input logic [7:0] c, input int n);
        logic [23:0] id;
        id = {m_ven, m_typ, m_cap};
        if (c == 8'h90 && n >= 32 && n < 40) return m_dev[39 - n];
        if (c == 8'h9F && n >= 8 && n < 32) return id[31 - n];
        return 1'b0;
    endfunction

    always @(negedge clk) begin
        if (model_clear) begin
            m_bits = 0; m_txn = 0; m_high_rises = 0; hi_cnt = 0; lo_cnt = 0;
            phase_bad = 0; mosi_bad = 0; m_cmd = 8'h00; m_addr = 24'h0;
            for (int i = 0; i < 4; i++) begin
                m_gap[i] = -1; m_txn_bits[i] = -1;
                m_txn_cmd[i] = 8'h00; m_txn_addr[i] = 24'hFFFFFF;
            end
        end else begin
            if (pcs && !spi_cs_n) begin
                if (m_txn < 4) m_gap[m_txn] = m_high_rises;
                m_high_rises = 0; m_bits = 0; m_cmd = 8'h00; m_addr = 24'h0;
            end
            if (!pcs && spi_cs_n) begin
                if (m_txn < 4) begin
                    m_txn_bits[m_txn] = m_bits;
                    m_txn_cmd[m_txn]  = m_cmd;
                    m_txn_addr[m_txn] = m_addr;
                end
                m_txn++;
            end
            if (spi_sck && !psck) begin
                if (spi_cs_n) begin
                    m_high_rises++;
                end else begin
                    if (m_bits < 8) m_cmd = {m_cmd[6:0], spi_mosi};
                    else if (m_bits < 32) m_addr = {m_addr[22:0], spi_mosi};
                    m_bits++;
                end
                if (lo_cnt < HALF) phase_bad++;
                lo_cnt = 0;
            end
            if (!spi_sck && psck && !spi_cs_n) spi_miso = resp_bit(m_cmd, m_bits);
            if (spi_sck) begin
                hi_cnt++;
            end else begin
                if (psck && hi_cnt != HALF) phase_bad++;
                hi_cnt = 0;
                if (busy) lo_cnt++;
            end
            if (spi_sck && psck && spi_mosi != pmosi) mosi_bad++;
        end
        psck = spi_sck; pcs = spi_cs_n; pmosi = spi_mosi;
    end

    // ---------------- checking helpers ----------------
    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run_probe(input logic [7:0] ven, input logic [7:0] typ,
                             input logic [7:0] cap, input logic [7:0] dev,
                             input bit poke);
        bit          ok, fk;
        logic [15:0] e_size;
        logic [7:0]  e_erase;
        logic [31:0] e_cnt;
        int          w;
        ok = (cap >= 8'd16) && (cap <= 8'd24);
        fk = (ven == 8'h01 && typ == 8'h40) || (ven == 8'h20 && typ == 8'hBA);
        e_size  = ok ? (fk ? 16'h800C : 16'h8010) : 16'h0000;
        e_erase = ok ? (fk ? 8'h20 : 8'hD8) : 8'h00;
        e_cnt   = ok ? (32'd1 << (cap - (fk ? 8'd12 : 8'd16))) : 32'd0;

        m_ven = ven; m_typ = typ; m_cap = cap; m_dev = dev;
        @(negedge clk); #1 model_clear = 1'b1;
        @(negedge clk); #1 model_clear = 1'b0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(busy == 1'b1, "R2", "busy after start", busy, 1);
        w = 0;
        while (!done && w < 8000) begin
            @(negedge clk);
            w++;
            start = poke && (w == 200);
        end
        start = 1'b0;
        chk(done == 1'b1, "R2", "done reached", done, 1);
        chk(busy == 1'b0, "R2", "busy low with done", busy, 0);
        // R3
        chk(m_gap[0] == 264, "R3", "idle+select clocks", m_gap[0], 264);
        // R5
        chk(m_txn_cmd[0] == 8'h90, "R5", "first opcode", m_txn_cmd[0], 8'h90);
        chk(m_txn_addr[0] == 24'h0, "R5", "address bits", m_txn_addr[0], 0);
        chk(m_txn_bits[0] == 40, "R5", "first transfer clocks", m_txn_bits[0], 40);
        chk(device == dev, "R5", "device byte", device, dev);
        // R6
        chk(m_gap[1] == 16, "R6", "deselect+select clocks", m_gap[1], 16);
        chk(m_txn_cmd[1] == 8'h9F, "R6", "second opcode", m_txn_cmd[1], 8'h9F);
        chk(m_txn_bits[1] == 32, "R6", "second transfer clocks", m_txn_bits[1], 32);
        chk(vendor == ven, "R6", "vendor byte", vendor, ven);
        chk(mem_type == typ, "R6", "memory type byte", mem_type, typ);
        chk(m_txn == 2, "R6", "transfer count", m_txn, 2);
        // R4
        chk(phase_bad == 0, "R4", "sck phase violations", phase_bad, 0);
        // R7
        chk(mosi_bad == 0, "R7", "mosi moved during high sck", mosi_bad, 0);
        // R12
        chk(m_high_rises == 8, "R12", "trailing deselect clocks", m_high_rises, 8);
        chk(spi_cs_n == 1'b1 && spi_sck == 1'b0, "R12", "bus idle at end",
            {spi_cs_n, spi_sck}, 2'b10);
        if (ok) begin
            // R9 and R10
            chk(enabled == 1'b1 && err_code == 8'd0 && spi_oe == 1'b1,
                fk ? "R10" : "R9", "enabled/err/oe", {enabled, err_code, spi_oe}, {1'b1, 8'd0, 1'b1});
            chk(sector_size == e_size, fk ? "R10" : "R9", "sector size", sector_size, e_size);
            chk(erase_op == e_erase, fk ? "R10" : "R9", "erase opcode", erase_op, e_erase);
            chk(sector_count == e_cnt, fk ? "R10" : "R9", "sector count", sector_count, e_cnt);
        end else begin
            // R8
            chk(enabled == 1'b0 && err_code == 8'd7 && spi_oe == 1'b0, "R8",
                "reject flags", {enabled, err_code, spi_oe}, {1'b0, 8'd7, 1'b0});
            chk(sector_size == 16'h0 && erase_op == 8'h0 && sector_count == 32'h0,
                "R8", "geometry cleared", {sector_size, erase_op, sector_count}, 0);
        end
        @(negedge clk);
        chk(done == 1'b0, "R2", "done one cycle", done, 0);
        if (poke) begin
            repeat (40) @(negedge clk);
            chk(busy == 1'b0, "R11", "busy after ignored start", busy, 0);
            chk(m_txn == 2, "R11", "no extra transfer", m_txn, 2);
        end
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        logic [7:0] pv [0:3];
        logic [7:0] pt [0:3];
        logic [7:0] caps [0:7];
        pv[0] = 8'h01; pt[0] = 8'h40;
        pv[1] = 8'h20; pt[1] = 8'hBA;
        pv[2] = 8'hEF; pt[2] = 8'h40;
        pv[3] = 8'h01; pt[3] = 8'hBA;
        caps[0] = 8'd12; caps[1] = 8'd15; caps[2] = 8'd16; caps[3] = 8'd17;
        caps[4] = 8'd20; caps[5] = 8'd23; caps[6] = 8'd24; caps[7] = 8'd25;

        repeat (3) @(negedge clk);
        // R1
        chk(busy == 0 && done == 0 && enabled == 0 && spi_oe == 0 && spi_sck == 0,
            "R1", "reset outputs low", {busy, done, enabled, spi_oe, spi_sck}, 0);
        chk(spi_cs_n == 1 && err_code == 0, "R1", "reset cs/err",
            {spi_cs_n, err_code}, {1'b1, 8'd0});
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(busy == 0 && spi_cs_n == 1, "R1", "idle after release",
            {busy, spi_cs_n}, 2'b01);

        for (int p = 0; p < 4; p++) begin
            for (int c = 0; c < 8; c++) begin
                run_probe(pv[p], pt[p], caps[c], 8'(8'h13 + p * 8 + c),
                          (p == 2 && c == 4));
            end
        end
        // R11 also covered on a 4 KB part after a rejected run
        run_probe(8'h20, 8'hBA, 8'd18, 8'hA5, 1'b1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule